// File: doc/BRIEF.md
# Hot-plug slot register controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. It also decides when the port tells software about a hot-plug event. Software reaches both registers through one 32-bit configuration write port. The control register sits in the low half of the word and the status register in the high half, and each byte lane has its own enable. The slot side drives two strobes: one for a device being added and one for the attention button being pressed. A level input gives the slot occupancy that holds while reset is asserted.

Every write that touches the control register counts as one command, and that command completes in the same cycle. An electromechanical interlock toggle request flips the lock status. A write that turns both power and the power indicator off on an occupied slot detaches the device. The block tracks whether an enabled event is pending. Each time that level changes, it signals software through one of three paths: a one-cycle message pulse for the extended message mode, a one-cycle pulse for the plain message mode, or a level interrupt line. Each message pulse carries a 5-bit message number.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While reset is asserted, the control register becomes: attention indicator off (bits 7:6 = 11), every enable clear, and interlock request clear. If `boot_present` is 1, the power indicator is on (bits 9:8 = 01) and power control is 0 (bit 10 = 0). Otherwise the power indicator is off (11) and power control is 1. The status register resets to zero except presence-detect state (status bit 6), which equals `boot_present`. `link_active` also equals `boot_present`.
- R2: A control write changes only the control bits whose byte lane is enabled (`cfg_be[1:0]`) and that are writable: bits 0, 3, 4, 5, 6 to 11. Bits 1, 2 and 12 to 15 always read 0.
- R3: Any write with `cfg_be[1:0]` nonzero is one command. Command-completed (status bit 4) reads 1 after that write.
- R4: Writing 1 to the interlock request (control bit 11) toggles the interlock status (status bit 7). Control bit 11 always reads 0.
- R5: Status bits 0, 3 and 4 are write-one-to-clear, gated by `cfg_be[3:2]`. All other status bits ignore writes. An event setting a bit in the same cycle wins over the clear.
- R6: A `hp_add` strobe sets presence-detect state, `link_active`, presence-detect-changed (bit 3) and attention-button (bit 0). A `hp_button` strobe sets bit 0.
- R7: A control write detaches the device when three things hold: presence-detect state was 1, the resulting power control bit is 1, and the resulting power indicator is 11. Detaching clears presence-detect state and `link_active` and sets presence-detect-changed. With the power indicator on, no detach happens.
- R8: The pending level is hot-plug enable (control bit 5) AND the OR of (status & control & 0x0019). When that level changes because of a command or an event, the block pulses `msix_pulse` if `msix_en` is 1, else `msi_pulse` if `msi_en` is 1. If neither is enabled, `intx_level` follows the new level.
- R9: A change of the pending level caused only by a status write produces no message pulse. In level mode it drops `intx_level` once nothing is pending.
- R10: A `hp_add` or `hp_button` strobe while interlock status is 1 is rejected. `hp_busy` pulses for one cycle and the status register is unchanged.
- R11: Each message pulse presents, on `irq_vec`, the `irq_vec_in` value from the triggering cycle.
- R12: Re-setting an event bit that is already 1 leaves the pending level unchanged, so no new message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_present | input | 1 | Slot occupancy applied while reset is asserted |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables: [1:0] control, [3:2] status |
| cfg_wdata | input | 32 | Write data: [15:0] control, [31:16] status |
| hp_add | input | 1 | Device hot-add strobe |
| hp_button | input | 1 | Attention button strobe |
| msix_en | input | 1 | Extended message mode enabled |
| msi_en | input | 1 | Plain message mode enabled |
| irq_vec_in | input | VEC_W | Interrupt message number field |
| cfg_rdata | output | 32 | Readback {status, control} |
| link_active | output | 1 | Data link layer link active status |
| msix_pulse | output | 1 | Extended message request, one cycle |
| msi_pulse | output | 1 | Plain message request, one cycle |
| intx_level | output | 1 | Level interrupt line |
| irq_vec | output | VEC_W | Message number sent with the last pulse |
| hp_busy | output | 1 | Event rejected because the slot is locked |

## Verification
The bench drives the interlock through both toggles and then sends a hot-add while locked. A design that ignored the lock would set presence and raise link active instead of flagging busy. It clears events while the message modes are active; a design that notified on every re-evaluation would emit a spurious pulse. Other tests set an event at the same time as its clear, and re-press a button that is already latched; a wrong priority would drop the event, and a design without change detection would send duplicate messages. Detach is tried both with the power indicator on and with it off, which catches a decode that tests only the power control bit.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W = 16;

  // control register field positions (software decodes these)
  localparam int C_ABPE = 0;
  localparam int C_PDCE = 3;
  localparam int C_CCIE = 4;
  localparam int C_HPIE = 5;
  localparam int C_AIND = 6;
  localparam int C_PIND = 8;
  localparam int C_PCTL = 10;
  localparam int C_LOCK = 11;

  // status register field positions
  localparam int S_ABP  = 0;
  localparam int S_PDC  = 3;
  localparam int S_CC   = 4;
  localparam int S_PDS  = 6;
  localparam int S_EIS  = 7;

  localparam logic [REG_W-1:0] CTL_WRITABLE = 16'h0FF9;
  localparam logic [REG_W-1:0] STS_W1C      = 16'h0019;
  localparam logic [REG_W-1:0] EVENT_MASK   = 16'h0019;

  localparam logic [1:0] IND_ON  = 2'b01;
  localparam logic [1:0] IND_OFF = 2'b11;

  function automatic logic [REG_W-1:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic pending_level(input logic [REG_W-1:0] ctl,
                                         input logic [REG_W-1:0] sts);
    return ctl[C_HPIE] && (|(sts & ctl & EVENT_MASK));
  endfunction

  function automatic logic [REG_W-1:0] ctl_reset_value(input logic populated);
    logic [REG_W-1:0] r;
    r = '0;
    r[C_AIND +: 2] = IND_OFF;
    r[C_PIND +: 2] = populated ? IND_ON : IND_OFF;
    r[C_PCTL]      = ~populated;
    return r;
  endfunction
endpackage

// File: rtl/hp_slot_ctl_reg.sv
module hp_slot_ctl_reg
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_present,
  input  logic             wr_en,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  input  logic             pds_q,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] ctl_next,
  output logic             cmd_hit,
  output logic             lock_toggle,
  output logic             detach_req
);
  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] merged;

  always_comb begin
    cmd_hit     = wr_en && (|be);
    wmask       = lane_mask(be) & CTL_WRITABLE;
    merged      = (ctl_q & ~wmask) | (wdata & wmask);
    lock_toggle = cmd_hit && merged[C_LOCK];
    ctl_next    = ctl_q;
    if (cmd_hit) begin
      ctl_next         = merged;
      ctl_next[C_LOCK] = 1'b0;
    end
    detach_req = cmd_hit && pds_q && ctl_next[C_PCTL] &&
                 (ctl_next[C_PIND +: 2] == IND_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= ctl_reset_value(boot_present);
    else        ctl_q <= ctl_next;
  end

  // R4: the interlock request never stays set after a command
  p_lock_req_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> !ctl_q[C_LOCK]);
endmodule

// File: rtl/hp_slot_sts_reg.sv
module hp_slot_sts_reg
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_present,
  input  logic             wr_en,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  input  logic             cmd_hit,
  input  logic             lock_toggle,
  input  logic             detach_req,
  input  logic             evt_add,
  input  logic             evt_button,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] sts_next,
  output logic             link_q,
  output logic             busy_q,
  output logic             sts_hit,
  output logic             notify_req
);
  logic             locked, reject, add_ok, btn_ok, link_next;
  logic [REG_W-1:0] clr_bits, set_bits;

  always_comb begin
    locked   = sts_q[S_EIS];
    reject   = (evt_add || evt_button) && locked;
    add_ok   = evt_add && !locked;
    btn_ok   = evt_button && !locked;
    sts_hit  = wr_en && (|be);
    clr_bits = sts_hit ? (lane_mask(be) & wdata & STS_W1C) : '0;
    set_bits = '0;
    if (cmd_hit)    set_bits[S_CC]  = 1'b1;
    if (detach_req) set_bits[S_PDC] = 1'b1;
    if (add_ok) begin
      set_bits[S_PDC] = 1'b1;
      set_bits[S_ABP] = 1'b1;
    end
    if (btn_ok)     set_bits[S_ABP] = 1'b1;
    sts_next = (sts_q & ~clr_bits) | set_bits;
    if (lock_toggle) sts_next[S_EIS] = ~sts_q[S_EIS];
    if (detach_req)  sts_next[S_PDS] = 1'b0;
    if (add_ok)      sts_next[S_PDS] = 1'b1;
    link_next = add_ok ? 1'b1 : (detach_req ? 1'b0 : link_q);
    notify_req = cmd_hit || add_ok || btn_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q        <= '0;
      sts_q[S_PDS] <= boot_present;
      link_q       <= boot_present;
      busy_q       <= 1'b0;
    end else begin
      sts_q  <= sts_next;
      link_q <= link_next;
      busy_q <= reject;
    end
  end

  // R3: each command leaves command-completed set
  p_cmd_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> sts_q[S_CC]);
  // R7: a detach drops presence and link and flags the change
  p_detach_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (detach_req && !evt_add) |=> (!sts_q[S_PDS] && !link_q && sts_q[S_PDC]));
  // R10: a rejected event leaves status untouched
  p_locked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !sts_hit && !cmd_hit) |=> (sts_q == $past(sts_q)));
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctl_next,
  input  logic [REG_W-1:0] sts_next,
  input  logic             notify_req,
  input  logic             sts_hit,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] vec_in,
  output logic             msix_pulse_q,
  output logic             msi_pulse_q,
  output logic             intx_q,
  output logic [VEC_W-1:0] vec_q
);
  logic pend_n, pending_q, changed, send_msg, level_mode;

  always_comb begin
    pend_n     = pending_level(ctl_next, sts_next);
    changed    = pend_n != pending_q;
    send_msg   = changed && notify_req && (msix_en || msi_en);
    level_mode = !msix_en && !msi_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q    <= 1'b0;
      msix_pulse_q <= 1'b0;
      msi_pulse_q  <= 1'b0;
      intx_q       <= 1'b0;
      vec_q        <= '0;
    end else begin
      pending_q    <= pend_n;
      msix_pulse_q <= send_msg && msix_en;
      msi_pulse_q  <= send_msg && !msix_en;
      if (level_mode && (changed || (sts_hit && !pend_n))) intx_q <= pend_n;
      if (send_msg) vec_q <= vec_in;
    end
  end

  // R8: one message kind at a time
  p_single_msg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(msix_pulse_q && msi_pulse_q));
  // R8/R12: a message only follows a change of the pending level
  p_msg_on_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_pulse_q || msi_pulse_q) |-> (pending_q != $past(pending_q)));
  // R9: status-only updates send no message
  p_clear_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !notify_req |=> !(msix_pulse_q || msi_pulse_q));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_present,
  input  logic             cfg_wr_en,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  input  logic             hp_add,
  input  logic             hp_button,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] irq_vec_in,
  output logic [31:0]      cfg_rdata,
  output logic             link_active,
  output logic             msix_pulse,
  output logic             msi_pulse,
  output logic             intx_level,
  output logic [VEC_W-1:0] irq_vec,
  output logic             hp_busy
);
  logic [REG_W-1:0] ctl_q, ctl_next, sts_q, sts_next;
  logic cmd_hit, lock_toggle, detach_req, sts_hit, notify_req;

  hp_slot_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .boot_present(boot_present),
    .wr_en(cfg_wr_en), .be(cfg_be[1:0]), .wdata(cfg_wdata[15:0]),
    .pds_q(sts_q[S_PDS]), .ctl_q(ctl_q), .ctl_next(ctl_next),
    .cmd_hit(cmd_hit), .lock_toggle(lock_toggle), .detach_req(detach_req)
  );

  hp_slot_sts_reg u_sts (
    .clk(clk), .rst_n(rst_n), .boot_present(boot_present),
    .wr_en(cfg_wr_en), .be(cfg_be[3:2]), .wdata(cfg_wdata[31:16]),
    .cmd_hit(cmd_hit), .lock_toggle(lock_toggle), .detach_req(detach_req),
    .evt_add(hp_add), .evt_button(hp_button),
    .sts_q(sts_q), .sts_next(sts_next), .link_q(link_active),
    .busy_q(hp_busy), .sts_hit(sts_hit), .notify_req(notify_req)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_ntf (
    .clk(clk), .rst_n(rst_n), .ctl_next(ctl_next), .sts_next(sts_next),
    .notify_req(notify_req), .sts_hit(sts_hit),
    .msix_en(msix_en), .msi_en(msi_en), .vec_in(irq_vec_in),
    .msix_pulse_q(msix_pulse), .msi_pulse_q(msi_pulse),
    .intx_q(intx_level), .vec_q(irq_vec)
  );

  assign cfg_rdata = {sts_q, ctl_q};

  // R2: read-only control bits never read as 1
  p_ro_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[15:12] == 4'h0) && (cfg_rdata[2:1] == 2'b00));
endmodule

// File: tb/hp_slot_ctrl_bench.sv
`timescale 1ns/1ps
module hp_slot_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_present = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic hp_add = 1'b0, hp_button = 1'b0, msix_en = 1'b0, msi_en = 1'b0;
  logic [4:0] irq_vec_in = '0;
  logic [31:0] cfg_rdata;
  logic link_active, msix_pulse, msi_pulse, intx_level, hp_busy;
  logic [4:0] irq_vec;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hp_slot_ctrl u_hp_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_present(boot_present),
    .cfg_wr_en(cfg_wr_en), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .hp_add(hp_add), .hp_button(hp_button), .msix_en(msix_en), .msi_en(msi_en),
    .irq_vec_in(irq_vec_in), .cfg_rdata(cfg_rdata), .link_active(link_active),
    .msix_pulse(msix_pulse), .msi_pulse(msi_pulse), .intx_level(intx_level),
    .irq_vec(irq_vec), .hp_busy(hp_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pop);
    @(negedge clk);
    rst_n = 1'b0; boot_present = pop;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_be = '0;
  endtask

  task automatic strobe(input logic add, input logic btn);
    @(negedge clk);
    hp_add = add; hp_button = btn;
    @(negedge clk);
    hp_add = 1'b0; hp_button = 1'b0;
  endtask

  task automatic t_reset_empty;
    do_reset(1'b0);
    chk("R1 rdata empty", cfg_rdata, 32'h0000_07C0);
    chk("R1 link empty", {31'b0, link_active}, 32'd0);
  endtask

  task automatic t_ctl_write;
    cfg_write(4'b0001, 32'h0000_FFFF);
    chk("R2 lane0 write", cfg_rdata, 32'h0010_07F9);
    chk("R8 intx rise", {31'b0, intx_level}, 32'd1);
  endtask

  task automatic t_w1c_clear;
    cfg_write(4'b0100, 32'h0010_0000);
    chk("R5 clear cc", cfg_rdata, 32'h0000_07F9);
    chk("R9 intx drop", {31'b0, intx_level}, 32'd0);
  endtask

  task automatic t_lock;
    cfg_write(4'b0010, 32'h0000_0800);
    chk("R4 lock set", cfg_rdata, 32'h0090_00F9);
    strobe(1'b1, 1'b0);
    chk("R10 busy", {31'b0, hp_busy}, 32'd1);
    chk("R10 status held", cfg_rdata, 32'h0090_00F9);
    chk("R10 link held", {31'b0, link_active}, 32'd0);
    cfg_write(4'b0010, 32'h0000_0800);
    chk("R4 lock release", cfg_rdata, 32'h0010_00F9);
    cfg_write(4'b0100, 32'h0010_0000);
  endtask

  task automatic t_msix_add;
    msix_en = 1'b1; irq_vec_in = 5'd19;
    strobe(1'b1, 1'b0);
    chk("R6 add status", cfg_rdata, 32'h0049_00F9);
    chk("R6 link up", {31'b0, link_active}, 32'd1);
    chk("R8 msix pulse", {30'b0, msix_pulse, msi_pulse}, 32'd2);
    chk("R11 vector", {27'b0, irq_vec}, 32'd19);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, msix_pulse}, 32'd0);
    strobe(1'b0, 1'b1);
    chk("R12 no resend", {30'b0, msix_pulse, msi_pulse}, 32'd0);
  endtask

  task automatic t_detach_off;
    cfg_write(4'b0011, 32'h0000_07F9);
    chk("R7 detach", cfg_rdata, 32'h0019_07F9);
    chk("R7 link down", {31'b0, link_active}, 32'd0);
  endtask

  task automatic t_msi;
    msix_en = 1'b0; msi_en = 1'b1;
    cfg_write(4'b1100, 32'hFFFF_0000);
    chk("R9 silent clear", cfg_rdata, 32'h0000_07F9);
    chk("R9 no msg", {30'b0, msix_pulse, msi_pulse}, 32'd0);
    irq_vec_in = 5'd7;
    strobe(1'b0, 1'b1);
    chk("R8 msi pulse", {30'b0, msix_pulse, msi_pulse}, 32'd1);
    chk("R11 msi vector", {27'b0, irq_vec}, 32'd7);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_be = 4'b0100; cfg_wdata = 32'h0001_0000; hp_button = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_be = '0; hp_button = 1'b0;
    chk("R5 set wins", cfg_rdata, 32'h0001_07F9);
    cfg_write(4'b1000, 32'h0001_0000);
    chk("R5 lane gated", cfg_rdata, 32'h0001_07F9);
    cfg_write(4'b0001, 32'h0000_00F9);
    chk("R3 cmd complete", cfg_rdata, 32'h0011_07F9);
    cfg_write(4'b0011, 32'h0000_F006);
    chk("R2 read-only bits", cfg_rdata, 32'h0011_0000);
    chk("R8 msi on fall", {31'b0, msi_pulse}, 32'd1);
    msi_en = 1'b0;
  endtask

  task automatic t_boot;
    do_reset(1'b1);
    chk("R1 rdata boot", cfg_rdata, 32'h0040_01C0);
    chk("R1 link boot", {31'b0, link_active}, 32'd1);
    cfg_write(4'b0011, 32'h0000_0500);
    chk("R7 no detach ind on", cfg_rdata, 32'h0050_0500);
    cfg_write(4'b0011, 32'h0000_07C0);
    chk("R7 detach boot", cfg_rdata, 32'h0018_07C0);
    chk("R7 link off", {31'b0, link_active}, 32'd0);
  endtask

  initial begin
    t_reset_empty();
    t_ctl_write();
    t_w1c_clear();
    t_lock();
    t_msix_add();
    t_detach_off();
    t_msi();
    t_boot();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule